// File: doc/BRIEF.md
# Flash Command and Status Front End

This block sits between a bus host and a flash operation engine. The host talks to it through one byte-wide command/data port. A write there is taken as a command code, or as the argument byte that a two-cycle command is still waiting for. A read there always returns the status byte. Byte programming and page erasure are two-cycle commands: the code comes first and the argument write follows. Mass erase, main/information block selection and error clearing act at once.

Operations that need the flash array go to a separate engine as a single-cycle request that carries a command and an argument byte. The engine reports back through a busy flag. While the engine works, the host polls the ready bit in the status byte. The block also holds the block selection (main or information memory), shows the active-low write-protect input as a lock flag, and records two error flags. A setup error is raised when a read arrives in place of an expected argument. A code error is raised when a code is not recognised. Command codes are parameters. The defaults are listed below.

Top module: `fcsi_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), eng_req is 0, main memory is selected (eng_info 0, status bit 3 = 0), both error flags are 0, and the next write is decoded as a command.
- R2: host_rdata always shows the status byte. Bit 7 is ready (1 when eng_busy is 0 and no request is being issued), bit 5 is the code error, bit 4 is the setup error, bit 3 is the information-block select, and bit 2 is lock, which equals the inverse of wp_n at all times, including during reset and clear. Bits 6, 1 and 0 read 0.
- R3: When the block is ready, a write of program (0x10) or page erase (0x20) arms the argument phase. The next write is the argument. In the cycle after that write, eng_req is high for exactly one cycle, with eng_cmd equal to the armed code and eng_arg equal to the argument byte.
- R4: If a read without a write arrives while the argument phase is armed, the setup error bit is set. The armed command is abandoned, no request is issued, and the next write is decoded as a command.
- R5: A correctly completed argument cycle leaves a clear setup error bit at 0.
- R6: Command 0x41 selects information memory and command 0x40 selects main memory. The selection shows on status bit 3 and on eng_info from the next cycle.
- R7: Command 0x4F clears bits 4 and 5 only. The block selection is unchanged.
- R8: When the block is ready, mass erase (0x30) issues a request in the next cycle with eng_cmd 0x30 and eng_arg 0x00.
- R9: A command write while the block is not ready (bit 7 = 0) is ignored. The selection, the error flags and the phase do not change, and no request is issued.
- R10: A write of any other code while ready sets the code error bit (bit 5).
- R11: When host_wr and host_rd are high in the same cycle, the write is processed and the read raises no setup error.
- R12: A read while no argument is armed has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the command/data port |
| host_rd | input | 1 | Host read strobe for the command/data port |
| host_wdata | input | 8 | Command code or argument byte |
| host_rdata | output | 8 | Status byte |
| wp_n | input | 1 | Active-low write-protect input |
| eng_busy | input | 1 | Flash engine busy flag |
| eng_req | output | 1 | Single-cycle operation request |
| eng_cmd | output | 8 | Command code carried with the request |
| eng_arg | output | 8 | Argument byte carried with the request |
| eng_info | output | 1 | Current block selection (1 = information memory) |

## Verification
Two host functions can fall in one cycle: a read and a write to the port together. The case that matters is when an argument is armed, because there the read alone would abort the command with a setup error while the write alone would complete it. The bench drives both strobes together during the argument phase, and also in the command phase. It judges that the request goes out with the written argument and that bit 4 stays clear. A second overlap, a command write landing in the cycle the engine is still busy or a request is leaving, is produced by random traffic against a bench engine model with random operation lengths. That overlap must leave every status bit untouched.

// File: rtl/fcsi_pkg.sv
// Package: shared types for the flash command/status front end.
// Assumes an 8-bit or wider host port; status bit positions are fixed.
package fcsi_pkg;

    // Decoded class of a command-phase write
    typedef enum logic [2:0] {
        CLS_TWO_CYCLE = 3'd0,
        CLS_MASS      = 3'd1,
        CLS_MAIN      = 3'd2,
        CLS_INFO      = 3'd3,
        CLS_CLEAR     = 3'd4,
        CLS_UNKNOWN   = 3'd5
    } cmd_class_t;

    // Status byte bit positions
    localparam int unsigned ST_READY = 7;
    localparam int unsigned ST_CERR  = 5;
    localparam int unsigned ST_SETUP = 4;
    localparam int unsigned ST_INFO  = 3;
    localparam int unsigned ST_LOCK  = 2;

endpackage

// File: rtl/fcsi_decode.sv
// Module: fcsi_decode
// Purely combinational classifier of a host byte into a command class.
// Assumes all code parameters are distinct.
module fcsi_decode #(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] CODE_PROG  = 8'h10,
    parameter logic [DW-1:0] CODE_PERASE = 8'h20,
    parameter logic [DW-1:0] CODE_MASS  = 8'h30,
    parameter logic [DW-1:0] CODE_MAIN  = 8'h40,
    parameter logic [DW-1:0] CODE_INFO  = 8'h41,
    parameter logic [DW-1:0] CODE_CLR   = 8'h4F
) (
    input  logic [DW-1:0]        code,
    output fcsi_pkg::cmd_class_t cls
);
    import fcsi_pkg::*;

    // Map the code onto its class; everything unlisted is unknown
    always_comb begin
        if (code == CODE_PROG || code == CODE_PERASE) cls = CLS_TWO_CYCLE;
        else if (code == CODE_MASS)                   cls = CLS_MASS;
        else if (code == CODE_MAIN)                   cls = CLS_MAIN;
        else if (code == CODE_INFO)                   cls = CLS_INFO;
        else if (code == CODE_CLR)                    cls = CLS_CLEAR;
        else                                          cls = CLS_UNKNOWN;
    end
endmodule

// File: rtl/fcsi_seq.sv
// Module: fcsi_seq
// Host-side sequencer: command phase versus armed argument phase, request
// issue to the engine, and one-cycle event strobes for the status register.
// Assumes 'ready' already folds in engine busy and an outgoing request.
module fcsi_seq #(
    parameter int unsigned DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [DW-1:0]        host_wdata,
    input  fcsi_pkg::cmd_class_t cls,
    input  logic                 ready,
    output logic                 arg_pend,
    output logic                 req,
    output logic [DW-1:0]        req_cmd,
    output logic [DW-1:0]        req_arg,
    output logic                 ev_main,
    output logic                 ev_info,
    output logic                 ev_clear,
    output logic                 ev_bad,
    output logic                 ev_setup
);
    import fcsi_pkg::*;

    logic [DW-1:0] armed_cmd;
    logic          cmd_ok;

    // A command-phase write is acted on only while ready
    always_comb cmd_ok = host_wr && !arg_pend && ready;

    // Event strobes toward the status register
    always_comb begin
        ev_main  = cmd_ok && (cls == CLS_MAIN);
        ev_info  = cmd_ok && (cls == CLS_INFO);
        ev_clear = cmd_ok && (cls == CLS_CLEAR);
        ev_bad   = cmd_ok && (cls == CLS_UNKNOWN);
        ev_setup = arg_pend && host_rd && !host_wr;
    end

    // Phase tracking and request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_pend  <= 1'b0;
            armed_cmd <= '0;
            req       <= 1'b0;
            req_cmd   <= '0;
            req_arg   <= '0;
        end else begin
            req <= 1'b0;
            if (host_wr && arg_pend) begin
                arg_pend <= 1'b0;
                req      <= 1'b1;
                req_cmd  <= armed_cmd;
                req_arg  <= host_wdata;
            end else if (cmd_ok && cls == CLS_TWO_CYCLE) begin
                arg_pend  <= 1'b1;
                armed_cmd <= host_wdata;
            end else if (cmd_ok && cls == CLS_MASS) begin
                req     <= 1'b1;
                req_cmd <= host_wdata;
                req_arg <= '0;
            end else if (ev_setup) begin
                arg_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fcsi_status.sv
// Module: fcsi_status
// Status register: block select and two sticky error flags, plus assembly
// of the status byte. Lock is taken live from the write-protect pin.
// Assumes DW >= 8.
module fcsi_status #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_main,
    input  logic          ev_info,
    input  logic          ev_clear,
    input  logic          ev_bad,
    input  logic          ev_setup,
    input  logic          ready,
    input  logic          wp_n,
    output logic          info_sel,
    output logic          setup_err,
    output logic          code_err,
    output logic [DW-1:0] status
);
    import fcsi_pkg::*;

    // Block selection; reset returns to main memory
    always_ff @(posedge clk) begin
        if (!rst_n)       info_sel <= 1'b0;
        else if (ev_info) info_sel <= 1'b1;
        else if (ev_main) info_sel <= 1'b0;
    end

    // Sticky error flags, cleared only by reset or the clear command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_err <= 1'b0;
            code_err  <= 1'b0;
        end else begin
            if (ev_clear)      setup_err <= 1'b0;
            else if (ev_setup) setup_err <= 1'b1;
            if (ev_clear)      code_err  <= 1'b0;
            else if (ev_bad)   code_err  <= 1'b1;
        end
    end

    // Status byte assembly
    always_comb begin
        status           = '0;
        status[ST_READY] = ready;
        status[ST_CERR]  = code_err;
        status[ST_SETUP] = setup_err;
        status[ST_INFO]  = info_sel;
        status[ST_LOCK]  = !wp_n;
    end
endmodule

// File: rtl/fcsi_ctrl.sv
// Module: fcsi_ctrl (top)
// Flash command/status front end: decodes host writes, forwards engine
// requests and presents the status byte on every read.
// Assumes the engine raises eng_busy the cycle after it sees eng_req.
module fcsi_ctrl #(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] CODE_PROG   = 8'h10,
    parameter logic [DW-1:0] CODE_PERASE = 8'h20,
    parameter logic [DW-1:0] CODE_MASS   = 8'h30,
    parameter logic [DW-1:0] CODE_MAIN   = 8'h40,
    parameter logic [DW-1:0] CODE_INFO   = 8'h41,
    parameter logic [DW-1:0] CODE_CLR    = 8'h4F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          wp_n,
    input  logic          eng_busy,
    output logic          eng_req,
    output logic [DW-1:0] eng_cmd,
    output logic [DW-1:0] eng_arg,
    output logic          eng_info
);
    import fcsi_pkg::*;

    cmd_class_t cls;
    logic ready, arg_pend;
    logic ev_main, ev_info, ev_clear, ev_bad, ev_setup;
    logic info_sel, setup_err, code_err;

    // Ready while the engine is idle and no request is on its way
    always_comb ready = !eng_busy && !eng_req;

    fcsi_decode #(
        .DW(DW), .CODE_PROG(CODE_PROG), .CODE_PERASE(CODE_PERASE),
        .CODE_MASS(CODE_MASS), .CODE_MAIN(CODE_MAIN),
        .CODE_INFO(CODE_INFO), .CODE_CLR(CODE_CLR)
    ) u_dec (
        .code (host_wdata),
        .cls  (cls)
    );

    fcsi_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .cls        (cls),
        .ready      (ready),
        .arg_pend   (arg_pend),
        .req        (eng_req),
        .req_cmd    (eng_cmd),
        .req_arg    (eng_arg),
        .ev_main    (ev_main),
        .ev_info    (ev_info),
        .ev_clear   (ev_clear),
        .ev_bad     (ev_bad),
        .ev_setup   (ev_setup)
    );

    fcsi_status #(.DW(DW)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_main   (ev_main),
        .ev_info   (ev_info),
        .ev_clear  (ev_clear),
        .ev_bad    (ev_bad),
        .ev_setup  (ev_setup),
        .ready     (ready),
        .wp_n      (wp_n),
        .info_sel  (info_sel),
        .setup_err (setup_err),
        .code_err  (code_err),
        .status    (host_rdata)
    );

    // Block selection exported to the engine
    always_comb eng_info = info_sel;
endmodule

// File: rtl/fcsi_ctrl_chk.sv
// Module: fcsi_ctrl_chk
// Protocol checker bound into fcsi_ctrl; observes ports and internal state.
module fcsi_ctrl_chk #(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] CODE_CLR = 8'h4F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic          host_rd,
    input logic [DW-1:0] host_wdata,
    input logic [DW-1:0] host_rdata,
    input logic          wp_n,
    input logic          eng_busy,
    input logic          eng_req,
    input logic          arg_pend,
    input logic          info_sel,
    input logic          setup_err,
    input logic          code_err
);
    // R1: reset returns the block to its idle state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!eng_req && !arg_pend && !info_sel && !setup_err && !code_err));

    // R2: lock bit follows the write-protect pin
    a_r2_lock_live: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[2] == !wp_n);

    // R3: requests last exactly one cycle
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    // R3 / R11: an argument write is forwarded, even with a read beside it
    a_r3_arg_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (arg_pend && host_wr) |=> (eng_req && !arg_pend && $stable(setup_err)));

    // R4: a read in place of the argument flags a setup error and aborts
    a_r4_setup_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (arg_pend && host_rd && !host_wr) |=> (setup_err && !arg_pend && !eng_req));

    // R7: clear-status drops the errors and keeps the block selection
    a_r7_clear_keeps_info: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !arg_pend && !eng_busy && !eng_req && host_wdata == CODE_CLR)
        |=> (!setup_err && !code_err && $stable(info_sel)));

    // R9: command writes while busy change nothing
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !arg_pend && eng_busy)
        |=> ($stable(info_sel) && $stable(code_err) && !arg_pend && !eng_req));

    // R12: a read with no argument armed has no side effect
    a_r12_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !arg_pend)
        |=> ($stable(setup_err) && $stable(info_sel) && !arg_pend));
endmodule

bind fcsi_ctrl fcsi_ctrl_chk #(.DW(DW), .CODE_CLR(CODE_CLR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .wp_n       (wp_n),
    .eng_busy   (eng_busy),
    .eng_req    (eng_req),
    .arg_pend   (arg_pend),
    .info_sel   (info_sel),
    .setup_err  (setup_err),
    .code_err   (code_err)
);

// File: tb/fcsi_ctrl_bench.sv
// Bench for fcsi_ctrl: reference model plus engine model, directed and
// seeded random host traffic. One host step per clock, driven at negedge.
module fcsi_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       wp_n = 1'b1;
    logic       eng_busy;
    logic       eng_req;
    logic [7:0] eng_cmd, eng_arg;
    logic       eng_info;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fcsi_ctrl u_fcsi_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .wp_n(wp_n),
        .eng_busy(eng_busy), .eng_req(eng_req), .eng_cmd(eng_cmd),
        .eng_arg(eng_arg), .eng_info(eng_info)
    );

    // Engine model: busy from the cycle after a request for a random length
    logic [3:0] eng_cnt;
    logic [3:0] next_len = 4'd2;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_busy <= 1'b0;
            eng_cnt  <= '0;
        end else if (eng_req) begin
            eng_busy <= 1'b1;
            eng_cnt  <= next_len;
        end else if (eng_cnt != 0) begin
            eng_cnt <= eng_cnt - 1'b1;
        end else begin
            eng_busy <= 1'b0;
        end
    end

    // Reference model state
    bit m_pend, m_info, m_setup, m_cerr, m_req;
    logic [7:0] m_armed, m_cmd, m_arg;

    function automatic logic [7:0] exp_status(bit busy, bit req, bit info,
                                              bit setup, bit cerr, logic wpn);
        return {!busy && !req, 1'b0, cerr, setup, info, !wpn, 2'b00};
    endfunction

    task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pend = 0; m_info = 0; m_setup = 0; m_cerr = 0; m_req = 0;
        m_armed = '0; m_cmd = '0; m_arg = '0;
    endtask

    // One host step: drive, check outputs, advance model
    task automatic step(bit wr, bit rd, logic [7:0] d, string tag);
        bit ready, nreq;
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_wdata = d;
        #1;
        check(eng_req == m_req, "R3/R8 req", {7'b0, eng_req}, {7'b0, m_req});
        if (m_req) begin
            check(eng_cmd == m_cmd, "R3/R8 cmd", eng_cmd, m_cmd);
            check(eng_arg == m_arg, "R3/R8 arg", eng_arg, m_arg);
        end
        check(eng_info == m_info, "R6 eng_info", {7'b0, eng_info}, {7'b0, m_info});
        check(host_rdata == exp_status(eng_busy, m_req, m_info, m_setup, m_cerr, wp_n),
              tag, host_rdata,
              exp_status(eng_busy, m_req, m_info, m_setup, m_cerr, wp_n));
        ready = !eng_busy && !m_req;
        nreq = 0;
        if (wr) begin
            if (m_pend) begin
                m_pend = 0; nreq = 1; m_cmd = m_armed; m_arg = d;
            end else if (ready) begin
                case (d)
                    8'h10, 8'h20: begin m_pend = 1; m_armed = d; end
                    8'h30: begin nreq = 1; m_cmd = d; m_arg = 8'h00; end
                    8'h40: m_info = 0;
                    8'h41: m_info = 1;
                    8'h4F: begin m_setup = 0; m_cerr = 0; end
                    default: m_cerr = 1;
                endcase
            end
        end else if (rd && m_pend) begin
            m_pend = 0; m_setup = 1;
        end
        m_req = nreq;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && (eng_busy || m_req); i++) step(0, 0, 8'h00, "R2 idle");
    endtask

    function automatic logic [7:0] pick_code();
        int r = $urandom_range(0, 9);
        case (r)
            0: return 8'h10;  1: return 8'h20;  2: return 8'h30;
            3: return 8'h40;  4: return 8'h41;  5: return 8'h4F;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        check(eng_req == 0, "R1 req", {7'b0, eng_req}, 8'h00);
        check(host_rdata == 8'h80, "R1 status", host_rdata, 8'h80);
        wp_n = 1'b0; #1;
        check(host_rdata == 8'h84, "R2 lock in reset", host_rdata, 8'h84);
        @(negedge clk); rst_n = 1'b1;

        // R6 then R7: select info, clear keeps it
        step(1, 0, 8'h41, "R6 set info");
        step(1, 0, 8'h55, "R10 unknown");
        step(1, 0, 8'h4F, "R7 clear");
        step(0, 1, 8'h00, "R7 info kept");
        // R3/R5: program with argument
        step(1, 0, 8'h10, "R3 arm");
        step(1, 0, 8'hA5, "R3 arg");
        step(0, 1, 8'h00, "R5 no setup err");
        wait_idle();
        // R4: read replaces argument
        step(1, 0, 8'h20, "R4 arm");
        step(0, 1, 8'h00, "R4 read");
        step(0, 1, 8'h00, "R4 setup shown");
        step(1, 0, 8'h40, "R4 next is command");
        step(0, 1, 8'h00, "R6 main");
        // R11: both strobes during argument phase
        step(1, 0, 8'h4F, "R7 clear");
        step(1, 0, 8'h20, "R11 arm");
        step(1, 1, 8'h3C, "R11 rd+wr");
        step(0, 1, 8'h00, "R11 no setup");
        // R9: command while busy
        step(0, 0, 8'h00, "R9 busy");
        step(1, 0, 8'h41, "R9 ignored info");
        step(1, 0, 8'h77, "R9 ignored bad");
        step(0, 1, 8'h00, "R9 unchanged");
        wait_idle();
        // R8: mass erase
        step(1, 0, 8'h30, "R8 mass");
        step(1, 0, 8'h20, "R9 during req");
        wait_idle();
        wp_n = 1'b1;
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 9);
            next_len = 4'($urandom_range(0, 6));
            if ($urandom_range(0, 15) == 0) wp_n = ~wp_n;
            if (op < 5)       step(1, 0, m_pend ? 8'($urandom) : pick_code(), "R2 random wr");
            else if (op < 8)  step(0, 1, 8'h00, "R12 random rd");
            else if (op < 9)  step(1, 1, pick_code(), "R11 random rd+wr");
            else              step(0, 0, 8'h00, "R2 random idle");
        end
        // R1: mid-run reset
        @(negedge clk); rst_n = 1'b0; host_wr = 0; host_rd = 0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        #1;
        check(host_rdata[5:3] == 3'b000 && eng_req == 0, "R1 re-reset", host_rdata, {host_rdata[7:6], 3'b000, host_rdata[2:0]});
        step(0, 1, 8'h00, "R1 after reset");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule